// File: doc/BRIEF.md
# Control Endpoint OUT Handshake Decider

This block decides how endpoint 0 of a USB function answers each OUT data packet. Two control bits steer it. The receive-enable bit lets payload reach the endpoint FIFO. The status-stage bit makes the endpoint answer the status phase of a control read automatically. For each packet, the serial engine signals where the packet starts, strobes every payload byte, and then marks where the packet ends. At the end it also reports whether the data PID was DATA1 and whether the CRC was good.

The block passes each payload byte to the FIFO with a write strobe when the transaction is headed for ACK. When the packet ends, it commits those bytes, or tells the FIFO to drop them if the CRC failed. One cycle after the end marker it issues the handshake code for the engine to send. It also clears its own control bits on SETUP tokens and on acknowledged OUTs, so firmware must re-arm them for each stage of a control transfer. The mode that governs a packet is sampled when the packet starts.

Top module: `ctl_out_responder`

## Requirements
- R1: After reset, both control bits read 0, and `hs_vld_o`, `fifo_commit_o`, `fifo_drop_o` and `fifo_wr_o` are low.
- R2: A cycle with `cfg_wr_i` high loads `cfg_en_out_i` into `en_out_o` and `cfg_stat_out_i` into `stat_out_o`; the new values are visible after that clock edge.
- R3: With the status-stage bit set at packet start, a good-CRC packet that is DATA1 and carries zero bytes is answered with ACK (`hs_o` = 2'b01). `hs_vld_o` pulses for one cycle, in the cycle after `pkt_end_i`.
- R4: With the status-stage bit set at packet start, any other good-CRC packet (DATA0, or one or more bytes) is answered with STALL (`hs_o` = 2'b11).
- R5: While the status-stage bit governs a packet, `fifo_wr_o` and `fifo_commit_o` stay low.
- R6: When both bits are set, the status-stage behaviour applies and the receive-enable behaviour does not.
- R7: With only the receive-enable bit set, every byte strobe raises `fifo_wr_o` in the same cycle, with `fifo_data_o` equal to `byte_i`. A good-CRC end is answered with ACK, and `fifo_commit_o` pulses together with `hs_vld_o`.
- R8: With neither bit set, a good-CRC packet is answered with NAK (`hs_o` = 2'b10) and nothing is written.
- R9: An ACK clears `en_out_o` at the same edge that raises `hs_vld_o`. NAK and STALL leave both bits unchanged, and ACK leaves `stat_out_o` unchanged.
- R10: A packet with a bad CRC gets no handshake (`hs_vld_o` low, `hs_o` = 2'b00) and changes neither bit. `fifo_drop_o` pulses in the cycle after the end marker when bytes of that packet were allowed into the FIFO.
- R11: `setup_i` clears both bits at the next edge. It wins over a firmware write in the same cycle.
- R12: A firmware write made during a packet does not change how that packet is answered; it applies from the next packet on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Firmware write strobe for the control bits |
| cfg_en_out_i | input | 1 | Receive-enable value to write |
| cfg_stat_out_i | input | 1 | Status-stage value to write |
| setup_i | input | 1 | SETUP token seen on endpoint 0 |
| pkt_start_i | input | 1 | OUT data packet begins |
| byte_vld_i | input | 1 | Payload byte strobe |
| byte_i | input | 8 | Payload byte |
| pkt_end_i | input | 1 | OUT data packet ends |
| data1_i | input | 1 | Packet PID was DATA1 (valid with pkt_end_i) |
| crc_ok_i | input | 1 | Packet CRC good (valid with pkt_end_i) |
| fifo_wr_o | output | 1 | FIFO byte write strobe |
| fifo_data_o | output | 8 | FIFO write data |
| fifo_commit_o | output | 1 | Keep the bytes written for this packet |
| fifo_drop_o | output | 1 | Discard the bytes written for this packet |
| hs_vld_o | output | 1 | Handshake to be sent |
| hs_o | output | 2 | Handshake code: 00 none, 01 ACK, 10 NAK, 11 STALL |
| en_out_o | output | 1 | Receive-enable bit |
| stat_out_o | output | 1 | Status-stage bit |

## Verification
The assertions assume that the serial engine frames packets cleanly. Each `pkt_start_i` is followed by byte strobes and exactly one `pkt_end_i`, and no byte strobe shares a cycle with either marker. The assertions also assume `setup_i` never arrives in the middle of an OUT packet. The bench drives every packet through one task that keeps this framing, drives inputs on falling edges, and issues SETUP only between packets. That keeps the stimulus within what the properties take for granted.

// File: rtl/ctl_out_pkg.sv
package ctl_out_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_e;
endpackage

// File: rtl/ctl_out_bits.sv
// Holds the receive-enable and status-stage control bits.
module ctl_out_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic cfg_en,
  input  logic cfg_stat,
  input  logic setup,
  input  logic ack_seen,
  output logic en_q,
  output logic stat_q
);
  logic en_d, stat_d;

  always_comb begin
    en_d   = en_q;
    stat_d = stat_q;
    if (cfg_wr) begin
      en_d   = cfg_en;
      stat_d = cfg_stat;
    end
    // hardware clears take precedence over firmware writes
    if (setup || ack_seen) en_d = 1'b0;
    if (setup) stat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      stat_q <= stat_d;
    end
  end

  // R11
  setup_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup |=> (!en_q && !stat_q));

  // R9
  ack_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_seen |=> !en_q);
endmodule

// File: rtl/ctl_out_track.sv
// Tracks one OUT packet: latches the governing mode at start, counts bytes.
module ctl_out_track #(
  parameter int MAX_BYTES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pkt_start,
  input  logic byte_vld,
  input  logic pkt_end,
  input  logic en_q,
  input  logic stat_q,
  output logic active,
  output logic wr_ok,
  output logic stat_lat,
  output logic zero_len,
  output logic fifo_wr
);
  localparam int CW = $clog2(MAX_BYTES + 1);
  localparam logic [CW-1:0] CMAX = CW'(MAX_BYTES);

  logic          act_d, wr_ok_d, stat_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = pkt_start || (active && byte_vld);

  always_comb begin
    act_d   = active;
    wr_ok_d = wr_ok;
    stat_d  = stat_lat;
    if (pkt_start) begin
      act_d   = 1'b1;
      stat_d  = stat_q;
      wr_ok_d = en_q && !stat_q;
    end else if (pkt_end) begin
      act_d = 1'b0;
    end
  end

  always_comb begin
    if (pkt_start)           cnt_d = '0;
    else if (cnt_q == CMAX)  cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      wr_ok    <= 1'b0;
      stat_lat <= 1'b0;
    end else begin
      active   <= act_d;
      wr_ok    <= wr_ok_d;
      stat_lat <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_len = (cnt_q == '0);
  assign fifo_wr  = active && byte_vld && wr_ok;

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CMAX);

  // R5
  stat_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && stat_lat) |-> !fifo_wr);
endmodule

// File: rtl/ctl_out_decide.sv
// Pure decision table for the handshake.
module ctl_out_decide
  import ctl_out_pkg::*;
(
  input  logic stat_lat,
  input  logic wr_ok,
  input  logic data1,
  input  logic zero_len,
  input  logic crc_ok,
  output hs_e  hs
);
  always_comb begin
    if (!crc_ok)       hs = HS_NONE;
    else if (stat_lat) hs = (data1 && zero_len) ? HS_ACK : HS_STALL;
    else if (wr_ok)    hs = HS_ACK;
    else               hs = HS_NAK;
  end
endmodule

// File: rtl/ctl_out_responder.sv
module ctl_out_responder
  import ctl_out_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int DW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_i,
  input  logic          cfg_en_out_i,
  input  logic          cfg_stat_out_i,
  input  logic          setup_i,
  input  logic          pkt_start_i,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] byte_i,
  input  logic          pkt_end_i,
  input  logic          data1_i,
  input  logic          crc_ok_i,
  output logic          fifo_wr_o,
  output logic [DW-1:0] fifo_data_o,
  output logic          fifo_commit_o,
  output logic          fifo_drop_o,
  output logic          hs_vld_o,
  output logic [1:0]    hs_o,
  output logic          en_out_o,
  output logic          stat_out_o
);
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic active, wr_ok, stat_lat, zero_len, fifo_wr;
  logic en_q, stat_q;
  hs_e  hs_dec;
  logic done, ack_seen;

  ctl_out_bits u_bits (
    .clk(clk), .rst_n(rst_s_n), .cfg_wr(cfg_wr_i), .cfg_en(cfg_en_out_i),
    .cfg_stat(cfg_stat_out_i), .setup(setup_i), .ack_seen(ack_seen),
    .en_q(en_q), .stat_q(stat_q)
  );

  ctl_out_track #(.MAX_BYTES(MAX_BYTES)) u_track (
    .clk(clk), .rst_n(rst_s_n), .pkt_start(pkt_start_i), .byte_vld(byte_vld_i),
    .pkt_end(pkt_end_i), .en_q(en_q), .stat_q(stat_q), .active(active),
    .wr_ok(wr_ok), .stat_lat(stat_lat), .zero_len(zero_len), .fifo_wr(fifo_wr)
  );

  ctl_out_decide u_dec (
    .stat_lat(stat_lat), .wr_ok(wr_ok), .data1(data1_i), .zero_len(zero_len),
    .crc_ok(crc_ok_i), .hs(hs_dec)
  );

  assign done     = pkt_end_i && active;
  assign ack_seen = done && (hs_dec == HS_ACK);

  logic hs_vld_d, commit_d, drop_d;
  hs_e  hs_d, hs_q;
  logic hs_vld_q, commit_q, drop_q;

  always_comb begin
    hs_vld_d = done && (hs_dec != HS_NONE);
    hs_d     = done ? hs_dec : HS_NONE;
    commit_d = ack_seen && wr_ok;
    drop_d   = done && !crc_ok_i && wr_ok;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      hs_vld_q <= 1'b0;
      hs_q     <= HS_NONE;
      commit_q <= 1'b0;
      drop_q   <= 1'b0;
    end else begin
      hs_vld_q <= hs_vld_d;
      hs_q     <= hs_d;
      commit_q <= commit_d;
      drop_q   <= drop_d;
    end
  end

  assign fifo_wr_o     = fifo_wr;
  assign fifo_data_o   = byte_i;
  assign fifo_commit_o = commit_q;
  assign fifo_drop_o   = drop_q;
  assign hs_vld_o      = hs_vld_q;
  assign hs_o          = hs_q;
  assign en_out_o      = en_q;
  assign stat_out_o    = stat_q;

  // R7
  commit_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    fifo_commit_o |-> (hs_vld_o && hs_o == HS_ACK));

  // R10
  drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    fifo_drop_o |-> (!hs_vld_o && !fifo_commit_o));

  // R9
  ack_en_low_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (hs_vld_o && hs_o == HS_ACK) |-> !en_out_o);

  // R5
  stall_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (hs_vld_o && hs_o == HS_STALL) |-> !fifo_commit_o);

  // R3
  hs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    hs_vld_o |=> !hs_vld_o);
endmodule

// File: tb/sim_ctl_out_responder.sv
module sim_ctl_out_responder;
  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr_i, cfg_en_out_i, cfg_stat_out_i, setup_i;
  logic pkt_start_i, byte_vld_i, pkt_end_i, data1_i, crc_ok_i;
  logic [7:0] byte_i;
  logic fifo_wr_o, fifo_commit_o, fifo_drop_o, hs_vld_o, en_out_o, stat_out_o;
  logic [7:0] fifo_data_o;
  logic [1:0] hs_o;

  always #4 clk = ~clk;

  ctl_out_responder u0 (.*);

  int total = 0;
  int fails = 0;

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic en; logic st; logic d1; logic [3:0] nb; logic crc;
    logic hsv; logic [1:0] hs; logic [3:0] wr; logic cm; logic dr;
    logic en_a; logic st_a;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0,4'd3,1'b1, 1'b1,2'b01,4'd3,1'b1,1'b0, 1'b0,1'b0}, // R7 R9
    '{1'b0,1'b0,1'b0,4'd2,1'b1, 1'b1,2'b10,4'd0,1'b0,1'b0, 1'b0,1'b0}, // R8
    '{1'b0,1'b1,1'b1,4'd0,1'b1, 1'b1,2'b01,4'd0,1'b0,1'b0, 1'b0,1'b1}, // R3
    '{1'b0,1'b1,1'b0,4'd0,1'b1, 1'b1,2'b11,4'd0,1'b0,1'b0, 1'b0,1'b1}, // R4
    '{1'b0,1'b1,1'b1,4'd2,1'b1, 1'b1,2'b11,4'd0,1'b0,1'b0, 1'b0,1'b1}, // R4 R5
    '{1'b1,1'b1,1'b1,4'd0,1'b1, 1'b1,2'b01,4'd0,1'b0,1'b0, 1'b0,1'b1}, // R6 R9
    '{1'b1,1'b1,1'b0,4'd4,1'b1, 1'b1,2'b11,4'd0,1'b0,1'b0, 1'b1,1'b1}, // R6 R5
    '{1'b1,1'b0,1'b1,4'd2,1'b0, 1'b0,2'b00,4'd2,1'b0,1'b1, 1'b1,1'b0}, // R10
    '{1'b0,1'b1,1'b1,4'd0,1'b0, 1'b0,2'b00,4'd0,1'b0,1'b0, 1'b0,1'b1}, // R10
    '{1'b1,1'b0,1'b0,4'd0,1'b1, 1'b1,2'b01,4'd0,1'b1,1'b0, 1'b0,1'b0}, // R7
    '{1'b1,1'b0,1'b1,4'd8,1'b1, 1'b1,2'b01,4'd8,1'b1,1'b0, 1'b0,1'b0}  // R7
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R7";  1: return "R8";  2: return "R3";  3: return "R4";
      4: return "R5";  5: return "R6";  6: return "R6";  7: return "R10";
      8: return "R10"; 9: return "R7";  default: return "R7";
    endcase
  endfunction

  task automatic cfg(logic en, logic st);
    @(negedge clk);
    cfg_wr_i = 1'b1; cfg_en_out_i = en; cfg_stat_out_i = st;
    @(negedge clk);
    cfg_wr_i = 1'b0;
  endtask

  // framed packet; returns write count, leaves sampling point after result edge
  int wr_cnt;
  int data_bad;
  task automatic pkt(logic d1, int nb, logic crc, logic mid_wr, logic mid_en);
    wr_cnt = 0; data_bad = 0;
    @(negedge clk);
    pkt_start_i = 1'b1;
    @(negedge clk);
    pkt_start_i = 1'b0;
    if (mid_wr) begin
      cfg_wr_i = 1'b1; cfg_en_out_i = mid_en; cfg_stat_out_i = 1'b0;
      @(negedge clk);
      cfg_wr_i = 1'b0;
    end
    for (int i = 0; i < nb; i++) begin
      byte_vld_i = 1'b1; byte_i = 8'(8'h30 + i);
      #1;
      if (fifo_wr_o) begin
        wr_cnt++;
        if (fifo_data_o != byte_i) data_bad++;
      end
      @(negedge clk);
    end
    byte_vld_i = 1'b0;
    pkt_end_i = 1'b1; data1_i = d1; crc_ok_i = crc;
    @(negedge clk);
    pkt_end_i = 1'b0;
    #1;
  endtask

  initial begin
    #(8 * 200000);
    fails++; total++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_wr_i = 0; cfg_en_out_i = 0; cfg_stat_out_i = 0; setup_i = 0;
    pkt_start_i = 0; byte_vld_i = 0; byte_i = 0; pkt_end_i = 0;
    data1_i = 0; crc_ok_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", "en", en_out_o, 0);
    chk("R1", "stat", stat_out_o, 0);
    chk("R1", "hs_vld", hs_vld_o, 0);
    chk("R1", "commit|drop|wr", fifo_commit_o | fifo_drop_o | fifo_wr_o, 0);

    // R2 firmware write
    cfg(1'b1, 1'b1);
    chk("R2", "en", en_out_o, 1);
    chk("R2", "stat", stat_out_o, 1);

    // R11 setup clears both
    @(negedge clk); setup_i = 1'b1;
    @(negedge clk); setup_i = 1'b0;
    chk("R11", "en", en_out_o, 0);
    chk("R11", "stat", stat_out_o, 0);

    // R11 setup wins over simultaneous write
    @(negedge clk); setup_i = 1'b1; cfg_wr_i = 1'b1; cfg_en_out_i = 1; cfg_stat_out_i = 1;
    @(negedge clk); setup_i = 1'b0; cfg_wr_i = 1'b0;
    chk("R11", "en after race", en_out_o, 0);
    chk("R11", "stat after race", stat_out_o, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      cfg(VEC[v].en, VEC[v].st);
      pkt(VEC[v].d1, int'(VEC[v].nb), VEC[v].crc, 1'b0, 1'b0);
      chk(vtag(v), $sformatf("v%0d hs_vld", v), hs_vld_o, VEC[v].hsv);
      chk(vtag(v), $sformatf("v%0d hs", v), hs_o, VEC[v].hs);
      chk(vtag(v), $sformatf("v%0d writes", v), wr_cnt, VEC[v].wr);
      chk(vtag(v), $sformatf("v%0d data", v), data_bad, 0);
      chk(vtag(v), $sformatf("v%0d commit", v), fifo_commit_o, VEC[v].cm);
      chk(vtag(v), $sformatf("v%0d drop", v), fifo_drop_o, VEC[v].dr);
      chk("R9", $sformatf("v%0d en after", v), en_out_o, VEC[v].en_a);
      chk("R9", $sformatf("v%0d stat after", v), stat_out_o, VEC[v].st_a);
      @(negedge clk);
      chk("R3", $sformatf("v%0d hs_vld one cycle", v), hs_vld_o, 0);
    end

    // R12 enable written mid-packet: packet still NAKed, bit survives NAK
    cfg(1'b0, 1'b0);
    pkt(1'b0, 2, 1'b1, 1'b1, 1'b1);
    chk("R12", "hs", hs_o, 2);
    chk("R12", "writes", wr_cnt, 0);
    chk("R12", "en kept after NAK", en_out_o, 1);
    // next packet uses the new setting
    pkt(1'b0, 1, 1'b1, 1'b0, 1'b0);
    chk("R12", "next hs", hs_o, 1);
    chk("R12", "next writes", wr_cnt, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule